// File: doc/BRIEF.md
# Event-Driven Kernel Accumulator

This block turns a stream of signed address events into updates of a grid of small integrate-and-fire cells. Each accepted event names one cell of the grid and carries a polarity. The block then walks a square projection field centred on that cell, one kernel row after another. For every grid cell the field covers, it fetches the matching kernel weight and the cell's current state. It adds the weight, or subtracts it for a negative event, saturates the result and writes the cell back.

A cell whose new value lies strictly above the positive threshold, or strictly below the negative threshold, is cleared to zero. That cell produces a one-cycle output event that carries its coordinates and its polarity. The kernel storage and the cell-state storage both sit outside the block. The kernel memory is read through a simple synchronous port. The state memory is shared with other agents and is reached through a request/grant pair. Loading the kernel and leaking the cells are handled by other logic.

Top module: `kac_core`

## Requirements
- R1: After reset, `ev_ready` is high and `st_req`, `out_valid` and `ev_done` are low.
- R2: For an event at (x, y) with effective kernel size K and half-width h = (K-1)/2, the weight at kernel address r*KMAX+c (row r, column c, KMAX = 11 by default) is combined with the cell at column x+c-h and row y+r-h. That cell's state address is row*64+column. A positive event (`ev_neg` = 0) adds the weight.
- R3: A negative event (`ev_neg` = 1) negates every weight before adding it, so a weight of -128 contributes +128.
- R4: Field positions whose column or row falls outside 0..63 are skipped, with no wrap-around. Every cell outside the field keeps its value.
- R5: The updated cell value saturates at 127 and at -128.
- R6: If the saturated value is strictly greater than `cfg_th_pos`, the cell is written as 0 and an output event with `out_neg` = 0 is produced. If it is strictly less than `cfg_th_neg`, the cell is written as 0 and `out_neg` = 1. Both thresholds are sampled when the event is accepted.
- R7: Exactly one output event is produced per firing cell. It carries the cell's column on `out_x` and its row on `out_y`, and output events follow the field in row-major order.
- R8: `cfg_ksize` is sampled at acceptance. An even value is raised to the next odd value (0 becomes 1), and any value above KMAX is clamped to KMAX.
- R9: `ev_ready` drops in the cycle after an event is accepted and stays low until the whole field has been processed.
- R10: `ev_done` is a single-cycle pulse, given once per event, in the cycle `ev_ready` returns high.
- R11: The state memory is accessed only in cycles where `st_req` and `st_gnt` are both high. While the grant is withheld, `st_req`, `st_addr` and `st_we` hold steady, and the final cell values do not depend on when the grant arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Input event present |
| ev_ready | output | 1 | Block can accept an event |
| ev_x | input | 6 | Event column |
| ev_y | input | 6 | Event row |
| ev_neg | input | 1 | Event polarity, 1 = negative |
| cfg_ksize | input | 4 | Requested kernel size |
| cfg_th_pos | input | 8 | Signed positive firing threshold |
| cfg_th_neg | input | 8 | Signed negative firing threshold |
| k_addr | output | 7 | Kernel memory read address |
| k_rdata | input | 8 | Signed kernel weight, one cycle after the address |
| st_req | output | 1 | State memory access request |
| st_gnt | input | 1 | State memory access grant |
| st_we | output | 1 | State access is a write |
| st_addr | output | 12 | State cell address |
| st_wdata | output | 8 | Signed cell value to write |
| st_rdata | input | 8 | Signed cell value, one cycle after a granted read |
| out_valid | output | 1 | Output event strobe |
| out_x | output | 6 | Firing cell column |
| out_y | output | 6 | Firing cell row |
| out_neg | output | 1 | Firing polarity, 1 = negative |
| ev_done | output | 1 | Event finished pulse |

## Verification
The bench builds the block with its default parameters: a 64 by 64 grid, 8-bit cells and weights, and a kernel limit of 11. With these values a full 11-wide field placed at a grid corner spills five positions past two edges, which exercises clipping on every side. They also make saturation, the -128 negation corner and kernel-size clamping (request 15 becomes 11) reachable with the real port widths. A second run of the firing scenario withholds the grant on alternate cycles to show that arbitration changes only the timing.

// File: rtl/kac_pkg.sv
package kac_pkg;

    localparam int CELL_W = 8;
    localparam int WGT_W  = 8;
    localparam int SUM_W  = ((CELL_W > WGT_W) ? CELL_W : WGT_W) + 2;

    typedef logic signed [CELL_W-1:0] cell_t;
    typedef logic signed [WGT_W-1:0]  wgt_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_CALC,
        PH_WRITE
    } phase_e;

    typedef struct packed {
        cell_t value;
        logic  fire;
        logic  fire_neg;
    } cell_upd_t;

    localparam cell_t CELL_MAX = cell_t'({1'b0, {(CELL_W-1){1'b1}}});
    localparam cell_t CELL_MIN = cell_t'({1'b1, {(CELL_W-1){1'b0}}});

    // Widened signed add or subtract of one weight into one cell.
    function automatic sum_t signed_step(input cell_t cur, input wgt_t w, input logic neg);
        sum_t a;
        sum_t b;
        a = sum_t'(cur);
        b = sum_t'(w);
        return neg ? (a - b) : (a + b);
    endfunction

    // Clamp a widened sum back into the cell range.
    function automatic cell_t clamp_cell(input sum_t s);
        if (s > sum_t'(CELL_MAX)) return CELL_MAX;
        if (s < sum_t'(CELL_MIN)) return CELL_MIN;
        return cell_t'(s);
    endfunction

endpackage

// File: rtl/kac_scan.sv
module kac_scan #(
    parameter int GRID_X = 64,
    parameter int GRID_Y = 64,
    parameter int KMAX   = 11,
    localparam int XW  = $clog2(GRID_X),
    localparam int YW  = $clog2(GRID_Y),
    localparam int KCW = $clog2(KMAX + 1),
    localparam int KAW = $clog2(KMAX * KMAX)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           step,
    input  logic [XW-1:0]  ev_x,
    input  logic [YW-1:0]  ev_y,
    input  logic [KCW-1:0] ksize_req,
    output logic [KAW-1:0] k_addr,
    output logic [XW-1:0]  cell_x,
    output logic [YW-1:0]  cell_y,
    output logic           in_range,
    output logic           last
);

    logic [KCW-1:0] row_q, col_q, ksz_q, half_q;
    logic [KCW-1:0] ksz_eff;
    logic [XW-1:0]  ox_q;
    logic [YW-1:0]  oy_q;
    logic           active_q;
    int             tx, ty;

    // Force an odd size and cap it at the kernel storage limit.
    always_comb begin
        ksz_eff = ksize_req | KCW'(1);
        if (ksz_eff > KCW'(KMAX)) ksz_eff = KCW'(KMAX);
    end

    assign last = active_q && (row_q == ksz_q - KCW'(1)) && (col_q == ksz_q - KCW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            col_q    <= '0;
            ksz_q    <= KCW'(1);
            half_q   <= '0;
            ox_q     <= '0;
            oy_q     <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            row_q    <= '0;
            col_q    <= '0;
            ksz_q    <= ksz_eff;
            half_q   <= ksz_eff >> 1;
            ox_q     <= ev_x;
            oy_q     <= ev_y;
            active_q <= 1'b1;
        end else if (step && active_q) begin
            if (last) begin
                active_q <= 1'b0;
            end else if (col_q == ksz_q - KCW'(1)) begin
                col_q <= '0;
                row_q <= row_q + KCW'(1);
            end else begin
                col_q <= col_q + KCW'(1);
            end
        end
    end

    always_comb begin
        tx = int'(ox_q) + int'(col_q) - int'(half_q);
        ty = int'(oy_q) + int'(row_q) - int'(half_q);
    end

    assign in_range = (tx >= 0) && (tx < GRID_X) && (ty >= 0) && (ty < GRID_Y);
    assign cell_x   = XW'(tx);
    assign cell_y   = YW'(ty);
    assign k_addr   = KAW'(int'(row_q) * KMAX + int'(col_q));

    // R8
    ksz_odd_chk: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (ksz_q[0] && (int'(ksz_q) <= KMAX)));

    // R2
    kaddr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (int'(k_addr) < KMAX * KMAX));

endmodule

// File: rtl/kac_cell.sv
module kac_cell
    import kac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap,
    input  cell_t     cur,
    input  wgt_t      wgt,
    input  logic      neg,
    input  cell_t     th_pos,
    input  cell_t     th_neg,
    output cell_upd_t res_q
);

    sum_t      sum;
    cell_t     sat;
    cell_upd_t nxt;

    always_comb begin
        sum          = signed_step(cur, wgt, neg);
        sat          = clamp_cell(sum);
        nxt.value    = sat;
        nxt.fire     = 1'b0;
        nxt.fire_neg = 1'b0;
        if (sat > th_pos) begin
            nxt.value = '0;
            nxt.fire  = 1'b1;
        end else if (sat < th_neg) begin
            nxt.value    = '0;
            nxt.fire     = 1'b1;
            nxt.fire_neg = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else if (cap) res_q <= nxt;
    end

    // R5
    sat_dir_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cap) && !$past(neg) && ($past(wgt) >= 0) && !res_q.fire)
            |-> ($signed(res_q.value) >= $signed($past(cur))));

endmodule

// File: rtl/kac_core.sv
module kac_core
    import kac_pkg::*;
#(
    parameter int GRID_X = 64,
    parameter int GRID_Y = 64,
    parameter int KMAX   = 11,
    localparam int XW  = $clog2(GRID_X),
    localparam int YW  = $clog2(GRID_Y),
    localparam int KCW = $clog2(KMAX + 1),
    localparam int KAW = $clog2(KMAX * KMAX),
    localparam int AW  = $clog2(GRID_X * GRID_Y)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ev_valid,
    output logic                     ev_ready,
    input  logic [XW-1:0]            ev_x,
    input  logic [YW-1:0]            ev_y,
    input  logic                     ev_neg,
    input  logic [KCW-1:0]           cfg_ksize,
    input  logic signed [CELL_W-1:0] cfg_th_pos,
    input  logic signed [CELL_W-1:0] cfg_th_neg,
    output logic [KAW-1:0]           k_addr,
    input  logic signed [WGT_W-1:0]  k_rdata,
    output logic                     st_req,
    input  logic                     st_gnt,
    output logic                     st_we,
    output logic [AW-1:0]            st_addr,
    output logic signed [CELL_W-1:0] st_wdata,
    input  logic signed [CELL_W-1:0] st_rdata,
    output logic                     out_valid,
    output logic [XW-1:0]            out_x,
    output logic [YW-1:0]            out_y,
    output logic                     out_neg,
    output logic                     ev_done
);

    phase_e    ph_q;
    logic      neg_q;
    cell_t     thp_q, thn_q;
    logic      done_q, ov_q, oneg_q;
    logic [XW-1:0] ox_q;
    logic [YW-1:0] oy_q;

    logic      accept, scan_step;
    logic [XW-1:0] cell_x;
    logic [YW-1:0] cell_y;
    logic      in_range, last;
    cell_upd_t res;

    assign ev_ready = (ph_q == PH_IDLE);
    assign accept   = ev_valid && ev_ready;

    kac_scan #(.GRID_X(GRID_X), .GRID_Y(GRID_Y), .KMAX(KMAX)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .step      (scan_step),
        .ev_x      (ev_x),
        .ev_y      (ev_y),
        .ksize_req (cfg_ksize),
        .k_addr    (k_addr),
        .cell_x    (cell_x),
        .cell_y    (cell_y),
        .in_range  (in_range),
        .last      (last)
    );

    kac_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .cap    (ph_q == PH_CALC),
        .cur    (st_rdata),
        .wgt    (k_rdata),
        .neg    (neg_q),
        .th_pos (thp_q),
        .th_neg (thn_q),
        .res_q  (res)
    );

    always_comb begin
        scan_step = 1'b0;
        st_req    = 1'b0;
        st_we     = 1'b0;
        unique case (ph_q)
            PH_READ: begin
                if (!in_range) scan_step = 1'b1;
                else st_req = 1'b1;
            end
            PH_WRITE: begin
                st_req = 1'b1;
                st_we  = 1'b1;
                if (st_gnt) scan_step = 1'b1;
            end
            default: ;
        endcase
    end

    assign st_addr  = AW'(int'(cell_y) * GRID_X + int'(cell_x));
    assign st_wdata = res.value;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            neg_q  <= 1'b0;
            thp_q  <= CELL_MAX;
            thn_q  <= CELL_MIN;
            done_q <= 1'b0;
            ov_q   <= 1'b0;
            oneg_q <= 1'b0;
            ox_q   <= '0;
            oy_q   <= '0;
        end else begin
            done_q <= 1'b0;
            ov_q   <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (accept) begin
                        neg_q <= ev_neg;
                        thp_q <= cfg_th_pos;
                        thn_q <= cfg_th_neg;
                        ph_q  <= PH_READ;
                    end
                end
                PH_READ: begin
                    if (!in_range) begin
                        if (last) begin
                            ph_q   <= PH_IDLE;
                            done_q <= 1'b1;
                        end
                    end else if (st_gnt) begin
                        ph_q <= PH_CALC;
                    end
                end
                PH_CALC: ph_q <= PH_WRITE;
                PH_WRITE: begin
                    if (st_gnt) begin
                        ov_q   <= res.fire;
                        oneg_q <= res.fire_neg;
                        ox_q   <= cell_x;
                        oy_q   <= cell_y;
                        if (last) begin
                            ph_q   <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            ph_q <= PH_READ;
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign out_valid = ov_q;
    assign out_neg   = oneg_q;
    assign out_x     = ox_q;
    assign out_y     = oy_q;
    assign ev_done   = done_q;

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ev_ready);

    // R10
    done_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ev_done |-> ev_ready);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        ev_done |=> !ev_done);

    // R6
    fire_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(st_req && st_gnt && st_we && (st_wdata == '0)));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_req && !st_gnt) |=> (st_req && $stable(st_addr) && $stable(st_we)));

endmodule

// File: tb/sim_kac_core.sv
module sim_kac_core;

    localparam int CLK_PERIOD = 10;
    localparam int KM = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              ev_valid = 1'b0;
    logic              ev_ready;
    logic [5:0]        ev_x = '0;
    logic [5:0]        ev_y = '0;
    logic              ev_neg = 1'b0;
    logic [3:0]        cfg_ksize = 4'd3;
    logic signed [7:0] cfg_th_pos = 8'sd127;
    logic signed [7:0] cfg_th_neg = -8'sd128;
    logic [6:0]        k_addr;
    logic signed [7:0] k_rdata;
    logic              st_req, st_gnt, st_we;
    logic [11:0]       st_addr;
    logic signed [7:0] st_wdata;
    logic signed [7:0] st_rdata;
    logic              out_valid, out_neg, ev_done;
    logic [5:0]        out_x, out_y;

    kac_core u0 (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_x(ev_x), .ev_y(ev_y), .ev_neg(ev_neg),
        .cfg_ksize(cfg_ksize), .cfg_th_pos(cfg_th_pos), .cfg_th_neg(cfg_th_neg),
        .k_addr(k_addr), .k_rdata(k_rdata),
        .st_req(st_req), .st_gnt(st_gnt), .st_we(st_we), .st_addr(st_addr),
        .st_wdata(st_wdata), .st_rdata(st_rdata),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_neg(out_neg),
        .ev_done(ev_done)
    );

    logic signed [7:0] smem [0:4095];
    logic signed [7:0] emem [0:4095];
    logic signed [7:0] kmem [0:KM*KM-1];
    logic mem_clear = 1'b0;
    logic deny_mode = 1'b0;
    logic gnt_ph = 1'b0;

    int checks = 0;
    int failures = 0;
    int fire_cnt = 0;
    int done_cnt = 0;
    logic [5:0] log_x [0:255];
    logic [5:0] log_y [0:255];
    logic       log_n [0:255];

    int exp_fires, exp_lx, exp_ly, exp_fx, exp_fy, exp_ln, ev_f0;

    // Memory models: kernel read and granted state access, one-cycle latency.
    always @(posedge clk) begin
        k_rdata <= kmem[k_addr];
        if (mem_clear) begin
            for (int a = 0; a < 4096; a++) smem[a] <= '0;
        end else if (st_req && st_gnt) begin
            if (st_we) smem[st_addr] <= st_wdata;
            else st_rdata <= smem[st_addr];
        end
    end

    always @(negedge clk) gnt_ph = ~gnt_ph;
    assign st_gnt = deny_mode ? gnt_ph : 1'b1;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            log_x[fire_cnt % 256] = out_x;
            log_y[fire_cnt % 256] = out_y;
            log_n[fire_cnt % 256] = out_neg;
            fire_cnt = fire_cnt + 1;
        end
        if (!rst && ev_done) done_cnt = done_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_state();
        @(negedge clk) mem_clear = 1'b1;
        @(negedge clk) mem_clear = 1'b0;
        for (int a = 0; a < 4096; a++) emem[a] = '0;
    endtask

    task automatic kernel_const(input int v);
        for (int i = 0; i < KM*KM; i++) kmem[i] = 8'(v);
    endtask

    task automatic kernel_ramp();
        for (int i = 0; i < KM*KM; i++) kmem[i] = 8'((i % 23) - 11);
    endtask

    // Reference model written from the requirements.
    task automatic ref_event(input int x, input int y, input bit neg, input int kreq,
                             input int thp, input int thn);
        int k, h, cx, cy, w, v, a;
        k = kreq | 1;
        if (k > KM) k = KM;
        h = k / 2;
        exp_fires = 0;
        for (int r = 0; r < k; r++) begin
            for (int c = 0; c < k; c++) begin
                cx = x + c - h;
                cy = y + r - h;
                if (cx >= 0 && cx < 64 && cy >= 0 && cy < 64) begin
                    a = cy * 64 + cx;
                    w = int'(kmem[r*KM + c]);
                    v = int'(emem[a]) + (neg ? -w : w);
                    if (v > 127) v = 127;
                    if (v < -128) v = -128;
                    if (v > thp || v < thn) begin
                        if (exp_fires == 0) begin exp_fx = cx; exp_fy = cy; end
                        exp_lx = cx; exp_ly = cy; exp_ln = (v < thn) ? 1 : 0;
                        exp_fires++;
                        v = 0;
                    end
                    emem[a] = 8'(v);
                end
            end
        end
    endtask

    task automatic run_event(input int x, input int y, input bit neg, input int kreq,
                             input int thp, input int thn, input string tag);
        int d0, bad, act_v, exp_v, n;
        ref_event(x, y, neg, kreq, thp, thn);
        ev_f0 = fire_cnt;
        d0 = done_cnt;
        @(negedge clk);
        ev_x = 6'(x); ev_y = 6'(y); ev_neg = neg; cfg_ksize = 4'(kreq);
        cfg_th_pos = 8'(thp); cfg_th_neg = 8'(thn);
        ev_valid = 1'b1;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        // R9: busy right after acceptance
        check(ev_ready == 1'b0, {"R9 ", tag}, int'(ev_ready), 0);
        n = 0;
        while (!ev_done && n < 20000) begin @(negedge clk); n++; end
        // R10: done coincides with ready
        check(ev_done && ev_ready, {"R10 ", tag}, int'(ev_ready), 1);
        @(negedge clk);
        check(!ev_done, {"R10 pulse ", tag}, int'(ev_done), 0);
        @(negedge clk);
        check(done_cnt - d0 == 1, {"R10 count ", tag}, done_cnt - d0, 1);
        bad = 0; act_v = 0; exp_v = 0;
        for (int a = 0; a < 4096; a++) begin
            if (smem[a] !== emem[a]) begin
                if (bad == 0) begin act_v = int'(smem[a]); exp_v = int'(emem[a]); end
                bad++;
            end
        end
        check(bad == 0, {"R2/R4 state ", tag}, act_v, exp_v);
        check(fire_cnt - ev_f0 == exp_fires, {"R7 fire count ", tag}, fire_cnt - ev_f0, exp_fires);
        if (exp_fires > 0 && fire_cnt > ev_f0) begin
            n = (fire_cnt - 1) % 256;
            check(int'(log_x[n]) == exp_lx && int'(log_y[n]) == exp_ly,
                  {"R7 last address ", tag}, int'(log_y[n]) * 64 + int'(log_x[n]), exp_ly * 64 + exp_lx);
            check(int'(log_n[n]) == exp_ln, {"R6 polarity ", tag}, int'(log_n[n]), exp_ln);
        end
    endtask

    task automatic t_reset();
        check(ev_ready == 1'b1, "R1 ready", int'(ev_ready), 1);
        check(st_req == 1'b0 && out_valid == 1'b0 && ev_done == 1'b0, "R1 idle outputs",
              int'({st_req, out_valid, ev_done}), 0);
    endtask

    task automatic t_centre();
        clear_state();
        kernel_ramp();
        run_event(20, 30, 1'b0, 3, 127, -128, "R2 centre k3");
        check(smem[29*64+19] == kmem[0], "R2 top-left weight", int'(smem[29*64+19]), int'(kmem[0]));
        run_event(32, 32, 1'b0, 11, 127, -128, "R2 centre k11");
    endtask

    task automatic t_negative();
        run_event(20, 30, 1'b1, 3, 127, -128, "R3 negative");
        check(smem[30*64+20] == 8'sd0, "R3 cancel", int'(smem[30*64+20]), 0);
        kmem[0] = -8'sd128;
        run_event(5, 50, 1'b1, 1, 127, -128, "R3 minus -128");
        check(smem[50*64+5] == 8'sd127, "R3 negated -128", int'(smem[50*64+5]), 127);
    endtask

    task automatic t_edges();
        clear_state();
        kernel_ramp();
        run_event(0, 0, 1'b0, 11, 127, -128, "R4 corner 0,0");
        run_event(63, 63, 1'b0, 11, 127, -128, "R4 corner 63,63");
        run_event(0, 63, 1'b1, 11, 127, -128, "R4 corner 0,63");
        check(smem[5*64+63] == 8'sd0, "R4 no wrap", int'(smem[5*64+63]), 0);
    endtask

    task automatic t_saturate();
        clear_state();
        kernel_const(100);
        run_event(40, 10, 1'b0, 3, 127, -128, "R5 up1");
        run_event(40, 10, 1'b0, 3, 127, -128, "R5 up2");
        check(smem[10*64+40] == 8'sd127, "R5 top clamp", int'(smem[10*64+40]), 127);
        run_event(40, 10, 1'b1, 3, 127, -128, "R5 dn1");
        run_event(40, 10, 1'b1, 3, 127, -128, "R5 dn2");
        run_event(40, 10, 1'b1, 3, 127, -128, "R5 dn3");
        check(smem[10*64+40] == -8'sd128, "R5 bottom clamp", int'(smem[10*64+40]), -128);
    endtask

    task automatic t_fire(input string tag);
        clear_state();
        kernel_const(30);
        run_event(10, 10, 1'b0, 3, 50, -50, {"R6 pos a ", tag});
        run_event(10, 10, 1'b0, 3, 50, -50, {"R6 pos b ", tag});
        check(fire_cnt - ev_f0 == 9, {"R6 nine fired ", tag}, fire_cnt - ev_f0, 9);
        run_event(10, 10, 1'b1, 3, 50, -50, {"R6 neg a ", tag});
        run_event(10, 10, 1'b1, 3, 50, -50, {"R6 neg b ", tag});
    endtask

    task automatic t_order();
        clear_state();
        kernel_const(5);
        run_event(63, 0, 1'b0, 3, 0, -128, "R7 edge order");
        check(int'(log_x[ev_f0 % 256]) == 62 && int'(log_y[ev_f0 % 256]) == 0, "R7 first address",
              int'(log_y[ev_f0 % 256]) * 64 + int'(log_x[ev_f0 % 256]), 62);
    endtask

    task automatic t_ksize();
        clear_state();
        kernel_ramp();
        run_event(30, 30, 1'b0, 4, 127, -128, "R8 even 4");
        check(smem[28*64+28] == kmem[0], "R8 size 5 reach", int'(smem[28*64+28]), int'(kmem[0]));
        run_event(12, 40, 1'b0, 15, 127, -128, "R8 clamp 15");
        run_event(50, 20, 1'b0, 0, 127, -128, "R8 zero");
    endtask

    task automatic t_grant();
        deny_mode = 1'b1;
        t_fire("R11 denied grant");
        deny_mode = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_centre();
        t_negative();
        t_edges();
        t_saturate();
        t_fire("plain");
        t_order();
        t_ksize();
        t_grant();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule